// File: doc/BRIEF.md
# SIMD Halving Add/Subtract Unit

This block is a lane-parallel arithmetic datapath working on two 128-bit operand vectors. Each lane produces the exact half of a widened sum or difference, so the result never wraps. The unit supports three operations: halving add, which rounds toward minus infinity; halving add with round-up; and halving subtract. Lanes can be 8, 16 or 32 bits wide, and their contents are read as either signed or unsigned. A narrow mode covers 64-bit vectors and forces the upper half of the output to zero.

Each lane extends its operands by one bit. The extension is a sign extension in signed mode and a zero extension in unsigned mode. The lane then forms the sum, the sum plus one, or the difference, and keeps bits [W:1] of that (W+1)-bit intermediate. The result is registered once and appears with `out_valid` one clock after `in_valid`.

Top module: `vhalf_unit`

## Requirements
- R1: With `op_sel`=2'b00, each lane returns floor((a+b)/2) of the extended operands, truncated to the lane width.
- R2: With `op_sel`=2'b01, each lane returns floor((a+b+1)/2) of the extended operands.
- R3: With `op_sel`=2'b10, each lane returns floor((a-b)/2) of the extended operands. For example, 0xF0 minus 0xF3 in 8-bit lanes gives 0xFE in both signed and unsigned modes.
- R4: With `op_sel`=2'b11, the registered result is all zero.
- R5: `lane_sz` selects the lane width: 2'b00 is 8 bits, 2'b01 is 16 bits and 2'b10 is 32 bits. Code 2'b11 gives an all-zero result.
- R6: With `is_signed`=1 the operands are sign-extended, and with `is_signed`=0 they are zero-extended. Two 8-bit examples: signed 0xF0 and 0xF3 give 0xF1. Unsigned 0xF0 and 0xF3 also give 0xF1, because the carry out of the lane is kept.
- R7: With `narrow`=1 (64-bit vector mode), result bits [127:64] are zero.
- R8: `out_valid` equals `in_valid` delayed by one clock, and `result` carries the value for the inputs sampled at that edge.
- R9: While `in_valid` is low, `result` holds its previous value.
- R10: While `rst` is high, and after it is released until the first valid input, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid |
| op_sel | input | 2 | 00 halving add, 01 rounding halving add, 10 halving subtract, 11 zero |
| lane_sz | input | 2 | 00 8-bit lanes, 01 16-bit, 10 32-bit, 11 zero |
| is_signed | input | 1 | 1 = signed lanes, 0 = unsigned |
| narrow | input | 1 | 1 = 64-bit vector, upper output half zero |
| a | input | 128 | First operand vector |
| b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result vector |

## Verification
On every cycle, the assertions check four things:
- the one-cycle valid timing;
- that the result holds while no input is valid;
- the zeroed upper half in narrow mode;
- the zero result for reserved operation and lane codes.

Inside each lane, two further assertions check that the halving add of equal operands returns the operand and that the halving subtract of equal operands returns zero. The arithmetic values themselves can only be shown by the bench, which covers every lane size, signedness and operation. It uses random operands, the directed sign and carry cases, and extreme values such as 0x80 with 0x80 and 0xFF with 0xFF.

// File: rtl/vhalf_pkg.sv
package vhalf_pkg;
  typedef enum logic [1:0] {
    OP_HADD  = 2'b00,
    OP_RHADD = 2'b01,
    OP_HSUB  = 2'b10,
    OP_NONE  = 2'b11
  } vh_op_e;

  typedef enum logic [1:0] {
    LS_8   = 2'b00,
    LS_16  = 2'b01,
    LS_32  = 2'b10,
    LS_RSV = 2'b11
  } vh_lsz_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/vhalf_lane.sv
module vhalf_lane
  import vhalf_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [1:0]        op,
  input  logic              sgn,
  output logic [LANE_W-1:0] res
);
  logic [LANE_W:0] ea, eb, wide;

  always_comb begin
    ea = {sgn & a[LANE_W-1], a};
    eb = {sgn & b[LANE_W-1], b};
    case (op)
      OP_HADD:  wide = ea + eb;
      OP_RHADD: wide = ea + eb + {{LANE_W{1'b0}}, 1'b1};
      OP_HSUB:  wide = ea - eb;
      default:  wide = '0;
    endcase
    res = wide[LANE_W:1];
  end

  always_comb begin
    // R1
    if (op == OP_HADD && a == b) begin
      hadd_equal_chk: assert (res == a);
    end
    // R3
    if (op == OP_HSUB && a == b) begin
      hsub_equal_chk: assert (res == '0);
    end
  end
endmodule

// File: rtl/vhalf_bank.sv
module vhalf_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [1:0]       op,
  input  logic             sgn,
  output logic [VEC_W-1:0] res
);
  localparam int N_LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    vhalf_lane #(.LANE_W(LANE_W)) u_lane (
      .a   (a[i*LANE_W +: LANE_W]),
      .b   (b[i*LANE_W +: LANE_W]),
      .op  (op),
      .sgn (sgn),
      .res (res[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vhalf_unit.sv
module vhalf_unit
  import vhalf_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int MIN_LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic [1:0]       lane_sz,
  input  logic             is_signed,
  input  logic             narrow,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] bank_res [NUM_SIZES];
  logic [VEC_W-1:0] sel_res, next_res;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    vhalf_bank #(.VEC_W(VEC_W), .LANE_W(MIN_LANE_W << k)) u_bank (
      .a   (a),
      .b   (b),
      .op  (op_sel),
      .sgn (is_signed),
      .res (bank_res[k])
    );
  end

  always_comb begin
    case (lane_sz)
      LS_8:    sel_res = bank_res[0];
      LS_16:   sel_res = bank_res[1];
      LS_32:   sel_res = bank_res[2];
      default: sel_res = '0;
    endcase
    next_res = sel_res;
    if (narrow) next_res[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  idle_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R7
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow) |=> (result[VEC_W-1:HALF_W] == '0));
  // R4
  reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_NONE) |=> (result == '0));
  // R5
  reserved_size_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sz == LS_RSV) |=> (result == '0));
endmodule

// File: tb/test_vhalf_unit.sv
`timescale 1ns/1ps
module test_vhalf_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   op_sel, lane_sz;
  logic         is_signed, narrow;
  logic [127:0] a, b;
  logic         out_valid;
  logic [127:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vhalf_unit i_vhalf_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .lane_sz(lane_sz), .is_signed(is_signed), .narrow(narrow),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] model(input logic [127:0] x, input logic [127:0] y,
                                         input logic [1:0] op, input logic [1:0] sz,
                                         input logic sg, input logic nar);
    logic [127:0] r = '0;
    int w;
    if (sz == 2'b11 || op == 2'b11) return '0;
    w = 8 << sz;
    for (int i = 0; i < 128 / w; i++) begin
      longint xv = 0, yv = 0, s;
      for (int j = 0; j < 64; j++) begin
        if (j < w) begin
          xv[j] = x[i*w + j];
          yv[j] = y[i*w + j];
        end else begin
          xv[j] = sg & x[i*w + w - 1];
          yv[j] = sg & y[i*w + w - 1];
        end
      end
      case (op)
        2'b00:   s = xv + yv;
        2'b01:   s = xv + yv + 1;
        default: s = xv - yv;
      endcase
      s = s >>> 1;
      for (int j = 0; j < 32; j++) if (j < w) r[i*w + j] = s[j];
    end
    if (nar) r[127:64] = '0;
    return r;
  endfunction

  task automatic chk(input logic [127:0] got, input logic [127:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [127:0] x, input logic [127:0] y, input logic [1:0] op,
                     input logic [1:0] sz, input logic sg, input logic nar,
                     input logic [127:0] exp, input string tag);
    a = x; b = y; op_sel = op; lane_sz = sz; is_signed = sg; narrow = nar;
    in_valid = 1'b1;
    @(negedge clk);
    chk({127'd0, out_valid}, 128'd1, {tag, " valid"});
    chk(result, exp, tag);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd42));
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; lane_sz = '0;
    is_signed = 1'b0; narrow = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({127'd0, out_valid}, 128'd0, "R10 out_valid in reset");
    chk(result, 128'd0, "R10 result in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(result, 128'd0, "R10 result after reset");

    // R6 R1 signed 8-bit halving add
    run({16{8'hF0}}, {16{8'hF3}}, 2'b00, 2'b00, 1'b1, 1'b0, {16{8'hF1}}, "R6 R1 signed hadd");
    // R2 rounding variant
    run({16{8'hF0}}, {16{8'hF3}}, 2'b01, 2'b00, 1'b1, 1'b0, {16{8'hF2}}, "R2 signed rhadd");
    // R6 unsigned, carry kept
    run({16{8'hF0}}, {16{8'hF3}}, 2'b00, 2'b00, 1'b0, 1'b0, {16{8'hF1}}, "R6 unsigned hadd");
    // R3 subtract in both modes
    run({16{8'hF0}}, {16{8'hF3}}, 2'b10, 2'b00, 1'b1, 1'b0, {16{8'hFE}}, "R3 signed hsub");
    run({16{8'hF0}}, {16{8'hF3}}, 2'b10, 2'b00, 1'b0, 1'b0, {16{8'hFE}}, "R3 unsigned hsub");
    // R5 16-bit lanes
    run({8{16'hFFF0}}, {8{16'hFFF1}}, 2'b00, 2'b01, 1'b0, 1'b0, {8{16'hFFF0}}, "R5 R1 u16 hadd");
    run({8{16'hFFF0}}, {8{16'hFFF1}}, 2'b01, 2'b01, 1'b0, 1'b0, {8{16'hFFF1}}, "R5 R2 u16 rhadd");
    // R6 extremes
    run({16{8'h80}}, {16{8'h80}}, 2'b00, 2'b00, 1'b1, 1'b0, {16{8'h80}}, "R6 signed min hadd");
    run({16{8'hFF}}, {16{8'hFF}}, 2'b01, 2'b00, 1'b0, 1'b0, {16{8'hFF}}, "R6 unsigned max rhadd");
    run({4{32'h0}}, {4{32'hFFFFFFFF}}, 2'b10, 2'b10, 1'b0, 1'b0, {4{32'h80000000}}, "R5 R3 u32 hsub");
    // R4 reserved op, R5 reserved size
    run({16{8'h55}}, {16{8'h33}}, 2'b11, 2'b00, 1'b0, 1'b0, 128'd0, "R4 reserved op");
    run({16{8'h55}}, {16{8'h33}}, 2'b00, 2'b11, 1'b0, 1'b0, 128'd0, "R5 reserved size");
    // R7 narrow mode
    run({16{8'h10}}, {16{8'h20}}, 2'b00, 2'b00, 1'b0, 1'b1, {64'd0, {8{8'h18}}}, "R7 narrow");

    // R9 hold while idle
    held = result;
    a = {4{32'hDEADBEEF}}; b = '1; op_sel = 2'b01;
    @(negedge clk);
    chk({127'd0, out_valid}, 128'd0, "R8 out_valid low when idle");
    chk(result, held, "R9 result held while idle");

    // R1 R2 R3 R5 R6 R7 random mix
    for (int n = 0; n < 400; n++) begin
      logic [127:0] x, y;
      logic [1:0] op, sz;
      logic sg, nar;
      x = {$urandom, $urandom, $urandom, $urandom};
      y = {$urandom, $urandom, $urandom, $urandom};
      op = 2'($urandom_range(0, 3));
      sz = 2'($urandom_range(0, 3));
      sg = 1'($urandom);
      nar = ($urandom_range(0, 7) == 0);
      run(x, y, op, sz, sg, nar, model(x, y, op, sz, sg, nar), "R1 R2 R3 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule